// File: doc/BRIEF.md
# Serial Register Access Port

This block is the host-facing serial port of a converter chip. An external host drives an active-low chip select, a serial clock and a data-in line to load four 8-bit control registers, to read them back, and to fetch the latest 24-bit conversion result. The control register contents are presented in parallel to the rest of the chip. A one-cycle pulse with the new result marks each completed conversion.

A single output pin serves two purposes. While a read is shifting out, it carries the read data. While chip select is high, it is an active-low "result ready" interrupt. Serial inputs are sampled into the system clock domain, and every frame action happens on a detected rising edge of the serial clock. The command length depends on its direction bit. A write header carries a 2-bit address. A read header carries a 3-bit address. A read of the result address returns 24 bits instead of 8.

Top module: `sreg_port`

## Requirements
- R1: After reset, all four control registers read 0x00 and the output pin is high.
- R2: A write frame consists of the bits 0, A1, A0, 0 followed by 8 data bits, MSB first. On the 8th data bit, the register at address {A1,A0} takes the byte.
- R3: A header of the form 1, A1, A0, 0 (direction 0 with the leading bit set) is discarded, and no register changes.
- R4: A read frame sends A2, A1, A0 and then a 1. For addresses 0 to 3, the pin then presents the register's 8 bits, MSB first. Each bit is valid before the serial clock pulse that follows it.
- R5: A read of address 4 presents the 24-bit result from bit 23 down to bit 0. A read of addresses 5 to 7 presents zero bits.
- R6: Raising chip select at any point abandons the frame. A write with fewer than 8 data bits changes no register.
- R7: A conversion pulse captures the result and sets a ready flag. While chip select is high, the pin is low when the flag is set and high when it is clear.
- R8: The start of a read of address 4 clears the ready flag. A conversion pulse in that same cycle, or at any later time, sets the flag again.
- R9: The result word is frozen at the start of a read. A conversion that completes during the read does not change the bits being shifted out.
- R10: Serial clock pulses after the end of a write frame, while chip select stays low, cause no further write.
- R11: While chip select is low and no read data phase is active, the pin is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Host chip select, active low |
| sclk | input | 1 | Host serial clock |
| sdin | input | 1 | Host serial data in |
| sdout_irq_n | output | 1 | Read data, or active-low ready interrupt while deselected |
| conv_valid | input | 1 | One-cycle pulse: new conversion result |
| conv_data | input | 24 | Conversion result, two's complement |
| ctrl_out | output | 32 | Control registers, register k in bits 8k+7..8k |

## Verification
The bench targets these cases:
- A write cut short by chip select. A design that counts across frames would later commit a stray byte.
- A header with the leading bit set. A design that ignores that bit would overwrite a register.
- Extra clock pulses after a complete write. A design that does not stop after the byte would write a second time.
- A conversion arriving in the middle of a result read. A design without the frozen copy would return a torn word. A design that clears the flag at the end of the read would lose the interrupt for the second result.
- Reads of unmapped addresses. A design that indexes past the register file would return stale data.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
   typedef enum logic [1:0] {
      PH_HDR   = 2'd0,
      PH_WDATA = 2'd1,
      PH_RDATA = 2'd2,
      PH_DONE  = 2'd3
   } phase_t;
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("sreg_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] pipe;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe <= RST_VAL;
         else        pipe <= d;
      end
   end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe <= {STAGES{RST_VAL}};
         else        pipe <= {pipe[STAGES-2:0], d};
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/sreg_frame.sv
module sreg_frame
   import sreg_pkg::*;
#(
   parameter int REG_W = 8,
   parameter int WR_AW = 2,
   parameter int RD_AW = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_act,
   input  logic             sk_rise,
   input  logic             di_s,
   output logic             wr_stb,
   output logic [WR_AW-1:0] wr_addr,
   output logic [REG_W-1:0] wr_data,
   output logic             rd_start,
   output logic [RD_AW-1:0] rd_addr,
   output logic             rd_shift,
   output logic             in_read
);
   localparam int HDR_BITS = RD_AW + 1;
   localparam int MAXLEN   = (REG_W > HDR_BITS) ? REG_W : HDR_BITS;
   localparam int CNT_W    = $clog2(MAXLEN) + 1;

   if (WR_AW + 2 != HDR_BITS) begin : g_bad_hdr
      $error("sreg_frame: write and read headers must have equal length");
   end
   if (REG_W < 2) begin : g_bad_w
      $error("sreg_frame: REG_W must be at least 2");
   end

   phase_t              phase;
   logic [CNT_W-1:0]    cnt;
   logic [HDR_BITS-1:0] hdr, hdr_nx;

   assign hdr_nx  = {hdr[HDR_BITS-2:0], di_s};
   assign in_read = (phase == PH_RDATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_HDR;
         cnt      <= '0;
         hdr      <= '0;
         wr_stb   <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
         rd_start <= 1'b0;
         rd_addr  <= '0;
         rd_shift <= 1'b0;
      end else begin
         wr_stb   <= 1'b0;
         rd_start <= 1'b0;
         rd_shift <= 1'b0;
         if (!cs_act) begin
            phase <= PH_HDR;
            cnt   <= '0;
         end else if (sk_rise) begin
            case (phase)
               PH_HDR: begin
                  hdr <= hdr_nx;
                  if (cnt == CNT_W'(HDR_BITS - 1)) begin
                     cnt <= '0;
                     if (hdr_nx[0]) begin
                        rd_start <= 1'b1;
                        rd_addr  <= hdr_nx[HDR_BITS-1:1];
                        phase    <= PH_RDATA;
                     end else if (!hdr_nx[HDR_BITS-1]) begin
                        wr_addr <= hdr_nx[WR_AW:1];
                        phase   <= PH_WDATA;
                     end else begin
                        phase <= PH_DONE;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               PH_WDATA: begin
                  wr_data <= {wr_data[REG_W-2:0], di_s};
                  if (cnt == CNT_W'(REG_W - 1)) begin
                     wr_stb <= 1'b1;
                     cnt    <= '0;
                     phase  <= PH_DONE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               PH_RDATA: rd_shift <= 1'b1;
               default: ;
            endcase
         end
      end
   end

   // one write per frame at most (R10)
   p_single_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);
   // a write commit never coincides with a read start (R2)
   p_wr_rd_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_stb && rd_start));
endmodule

// File: rtl/sreg_ctrlfile.sv
module sreg_ctrlfile #(
   parameter int REG_W  = 8,
   parameter int N_REGS = 4,
   parameter int WR_AW  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_stb,
   input  logic [WR_AW-1:0]        wr_addr,
   input  logic [REG_W-1:0]        wr_data,
   output logic [N_REGS*REG_W-1:0] regs_flat
);
   if (N_REGS != (1 << WR_AW)) begin : g_bad_n
      $error("sreg_ctrlfile: N_REGS must equal 2**WR_AW");
   end

   logic [N_REGS-1:0] we;

   for (genvar i = 0; i < N_REGS; i++) begin : g_reg
      assign we[i] = wr_stb && (wr_addr == WR_AW'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     regs_flat[i*REG_W +: REG_W] <= '0;
         else if (we[i]) regs_flat[i*REG_W +: REG_W] <= wr_data;
      end
   end

   // at most one register enabled at a time (R2)
   p_onehot_we_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(we));
   // registers move only after a completed write frame (R6)
   p_change_needs_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(regs_flat) |-> $past(wr_stb));
endmodule

// File: rtl/sreg_txpath.sv
module sreg_txpath #(
   parameter int REG_W  = 8,
   parameter int N_REGS = 4,
   parameter int RES_W  = 24,
   parameter int RD_AW  = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cs_act,
   input  logic                    rd_start,
   input  logic [RD_AW-1:0]        rd_addr,
   input  logic                    rd_shift,
   input  logic                    in_read,
   input  logic                    conv_valid,
   input  logic [RES_W-1:0]        conv_data,
   input  logic [N_REGS*REG_W-1:0] regs_flat,
   output logic                    dout
);
   localparam int RES_ADDR = N_REGS;

   if (RES_W <= REG_W) begin : g_bad_res
      $error("sreg_txpath: RES_W must exceed REG_W");
   end
   if (RES_ADDR >= (1 << RD_AW)) begin : g_bad_addr
      $error("sreg_txpath: result address does not fit the read address");
   end

   logic [RES_W-1:0] res_q;
   logic [RES_W-1:0] shreg;
   logic             ready_q;
   logic [REG_W-1:0] sel;
   logic             rd_res;

   assign rd_res = (rd_addr == RD_AW'(RES_ADDR));

   always_comb begin
      sel = '0;
      for (int i = 0; i < N_REGS; i++)
         if (rd_addr == RD_AW'(i)) sel = regs_flat[i*REG_W +: REG_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q   <= '0;
         ready_q <= 1'b0;
         shreg   <= '0;
      end else begin
         if (conv_valid)                res_q <= conv_data;
         if (conv_valid)                ready_q <= 1'b1;
         else if (rd_start && rd_res)   ready_q <= 1'b0;
         if (rd_start) begin
            if (rd_res) shreg <= res_q;
            else        shreg <= {sel, {(RES_W-REG_W){1'b0}}};
         end else if (rd_shift) begin
            shreg <= {shreg[RES_W-2:0], 1'b0};
         end
      end
   end

   always_comb begin
      if (!cs_act)      dout = ~ready_q;
      else if (in_read) dout = shreg[RES_W-1];
      else              dout = 1'b1;
   end

   p_ready_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      conv_valid |=> ready_q);
   p_ready_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_start && rd_res && !conv_valid) |=> !ready_q);
   p_frozen_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_start && !rd_shift) |=> $stable(shreg));
endmodule

// File: rtl/sreg_port.sv
module sreg_port #(
   parameter int REG_W       = 8,
   parameter int N_REGS      = 4,
   parameter int RES_W       = 24,
   parameter int WR_AW       = 2,
   parameter int RD_AW       = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sel_n,
   input  logic                    sclk,
   input  logic                    sdin,
   output logic                    sdout_irq_n,
   input  logic                    conv_valid,
   input  logic [RES_W-1:0]        conv_data,
   output logic [N_REGS*REG_W-1:0] ctrl_out
);
   logic sk_s, cs_n_s, di_s, sk_prev, sk_rise, cs_act;
   logic             wr_stb, rd_start, rd_shift, in_read;
   logic [WR_AW-1:0] wr_addr;
   logic [REG_W-1:0] wr_data;
   logic [RD_AW-1:0] rd_addr;

   sreg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sk (
      .clk(clk), .rst_n(rst_n), .d(sclk),  .q(sk_s));
   sreg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
      .clk(clk), .rst_n(rst_n), .d(sel_n), .q(cs_n_s));
   sreg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_di (
      .clk(clk), .rst_n(rst_n), .d(sdin),  .q(di_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sk_prev <= 1'b0;
      else        sk_prev <= sk_s;
   end

   assign sk_rise = sk_s && !sk_prev;
   assign cs_act  = !cs_n_s;

   sreg_frame #(.REG_W(REG_W), .WR_AW(WR_AW), .RD_AW(RD_AW)) u_frame (
      .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sk_rise(sk_rise),
      .di_s(di_s), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_start(rd_start), .rd_addr(rd_addr), .rd_shift(rd_shift),
      .in_read(in_read));

   sreg_ctrlfile #(.REG_W(REG_W), .N_REGS(N_REGS), .WR_AW(WR_AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
      .wr_data(wr_data), .regs_flat(ctrl_out));

   sreg_txpath #(.REG_W(REG_W), .N_REGS(N_REGS), .RES_W(RES_W),
                 .RD_AW(RD_AW)) u_tx (
      .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .rd_start(rd_start),
      .rd_addr(rd_addr), .rd_shift(rd_shift), .in_read(in_read),
      .conv_valid(conv_valid), .conv_data(conv_data),
      .regs_flat(ctrl_out), .dout(sdout_irq_n));
endmodule

// File: tb/tb_sreg_port.sv
module tb_sreg_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel_n = 1'b1, sclk = 1'b0, sdin = 1'b0;
   logic        conv_valid = 1'b0;
   logic [23:0] conv_data = '0;
   logic        sdout_irq_n;
   logic [31:0] ctrl_out;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;
   logic [23:0] exp_q[$], act_q[$];
   string       tag_q[$];

   always #4 clk = ~clk;

   sreg_port dut (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdin(sdin),
      .sdout_irq_n(sdout_irq_n), .conv_valid(conv_valid),
      .conv_data(conv_data), .ctrl_out(ctrl_out));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         wait (act_q.size() > 0);
         if (exp_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL scoreboard: actual %h expected none", act_q.pop_front());
         end else begin
            check(tag_q.pop_front(), {8'h0, act_q.pop_front()}, {8'h0, exp_q.pop_front()});
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   task automatic expect_word(input string tag, input logic [23:0] v);
      exp_q.push_back(v);
      tag_q.push_back(tag);
   endtask

   task automatic bit_io(input logic b, output logic s);
      sdin = b;
      repeat (6) @(negedge clk);
      s = sdout_irq_n;
      sclk = 1'b1;
      repeat (6) @(negedge clk);
      sclk = 1'b0;
   endtask

   task automatic cs_low();
      @(negedge clk); sel_n = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic cs_high();
      sel_n = 1'b1; sdin = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic send_bits(input logic [31:0] v, input int n);
      logic s;
      for (int i = n - 1; i >= 0; i--) bit_io(v[i], s);
   endtask

   task automatic wr_frame(input logic [1:0] a, input logic [7:0] d);
      cs_low();
      send_bits({20'h0, 1'b0, a, 1'b0, d}, 12);
      cs_high();
   endtask

   task automatic conv_pulse(input logic [23:0] v);
      @(negedge clk); conv_valid = 1'b1; conv_data = v;
      @(negedge clk); conv_valid = 1'b0;
   endtask

   // read frame; optional conversion pulse after bit conv_at of the data phase
   task automatic rd_frame(input logic [2:0] a, input int nbits, input int conv_at,
                           input logic [23:0] conv_v, output logic hdr_hi);
      logic s;
      logic [23:0] w = '0;
      hdr_hi = 1'b1;
      cs_low();
      for (int i = 3; i >= 0; i--) begin
         bit_io((i == 0) ? 1'b1 : a[i-1], s);
         hdr_hi = hdr_hi & s;
      end
      for (int i = 0; i < nbits; i++) begin
         if (i == conv_at) conv_pulse(conv_v);
         bit_io(1'b0, s);
         w = {w[22:0], s};
      end
      cs_high();
      act_q.push_back(w);
   endtask

   initial begin
      logic h;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check("R1 ctrl reset", ctrl_out, 32'h0);
      check("R1 pin idle", {31'h0, sdout_irq_n}, 32'h1);

      // R2 writes, R4 readback
      wr_frame(2'd0, 8'hA5);
      wr_frame(2'd1, 8'h3C);
      wr_frame(2'd2, 8'h81);
      wr_frame(2'd3, 8'h7E);
      check("R2 write all", ctrl_out, 32'h7E813CA5);
      expect_word("R4 read reg0", 24'hA5); rd_frame(3'd0, 8, -1, 0, h);
      expect_word("R4 read reg1", 24'h3C); rd_frame(3'd1, 8, -1, 0, h);
      expect_word("R4 read reg2", 24'h81); rd_frame(3'd2, 8, -1, 0, h);
      expect_word("R4 read reg3", 24'h7E); rd_frame(3'd3, 8, -1, 0, h);

      // R6 aborted write
      cs_low(); send_bits({1'b0, 2'd1, 1'b0, 5'b11111}, 9); cs_high();
      check("R6 partial write", ctrl_out, 32'h7E813CA5);
      wr_frame(2'd1, 8'h96);
      check("R6 next frame clean", ctrl_out, 32'h7E8196A5);

      // R3 leading bit set
      cs_low(); send_bits({1'b1, 2'd2, 1'b0, 8'h55}, 12); cs_high();
      check("R3 discarded header", ctrl_out, 32'h7E8196A5);

      // R10 trailing pulses
      cs_low(); send_bits({1'b0, 2'd3, 1'b0, 8'h11, 8'hFF, 4'h0}, 24); cs_high();
      check("R10 no second write", ctrl_out, 32'h118196A5);

      // R5 unmapped addresses
      expect_word("R5 addr5 zero", 24'h0); rd_frame(3'd5, 8, -1, 0, h);
      expect_word("R5 addr7 zero", 24'h0); rd_frame(3'd7, 8, -1, 0, h);

      // R7 ready interrupt, R5 result read, R8 clear
      conv_pulse(24'h123456);
      repeat (4) @(negedge clk);
      check("R7 pin low when ready", {31'h0, sdout_irq_n}, 32'h0);
      expect_word("R5 result read", 24'h123456); rd_frame(3'd4, 24, -1, 0, h);
      check("R11 header phase high", {31'h0, h}, 32'h1);
      check("R8 cleared after read", {31'h0, sdout_irq_n}, 32'h1);

      // R9 conversion during read
      conv_pulse(24'hABCDEF);
      expect_word("R9 frozen word", 24'hABCDEF); rd_frame(3'd4, 24, 6, 24'h0F0F0F, h);
      check("R8 flag set by mid-read conversion", {31'h0, sdout_irq_n}, 32'h0);
      expect_word("R9 second result", 24'h0F0F0F); rd_frame(3'd4, 24, -1, 0, h);
      check("R8 cleared again", {31'h0, sdout_irq_n}, 32'h1);

      // R7 register read does not clear the flag
      conv_pulse(24'h800001);
      expect_word("R4 read reg3 after writes", 24'h11); rd_frame(3'd3, 8, -1, 0, h);
      check("R7 flag kept over register read", {31'h0, sdout_irq_n}, 32'h0);
      expect_word("R5 negative result", 24'h800001); rd_frame(3'd4, 24, -1, 0, h);

      wait (act_q.size() == 0);
      repeat (4) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_cmp++; n_bad++;
         $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
      end
      done = 1;
      report();
   end
endmodule